// File: doc/BRIEF.md
# Power-Up Soft-Start Sequencer

This block orders the bring-up of a set of supply rails once bias power is valid or a forced shutdown is released. The analog soft-start node is modelled as an unsigned ramp code. On start, the code is charged quickly to a starting level. It then climbs one step at a time to bring up the standby rail. At the top of that climb the standby monitor is armed and the code drops back to the ramp base level.

A fixed wait follows. At the end of it the configuration inputs and the memory-voltage comparator are captured, and the block picks one of two paths:

- **Sleep path.** A second ramp brings up the remaining rails.
- **Active path.** This path is taken when both sleep-request inputs are high, which means no sleep is requested. The block first waits until the main supplies have been good for an unbroken timeout. Only then does it enable the external drivers and the clock rail, and ramp once more.

In both paths the rail monitors are armed at the top of the final ramp, and the code then parks. A shutdown request at any time clears the sequence, and releasing it restarts the sequence from the beginning.

Top module: `softstart_seq`

## Requirements
- R1: While reset or shutdown holds the block idle, `seqPhase` is 0 (off), `rampLevel` is 0, `activeEn` is 0 and no strobe is high.
- R2: When leaving the off phase, `rampLevel` goes from 0 straight to FAST_CODE, with no intermediate value.
- R3: During a climb, `rampLevel` rises by exactly one code every STEP_DIV cycles. It never jumps by more than one code upward, except for the fast-charge load from 0.
- R4: In the standby climb (phase 2), `sbyMonStb` pulses in the cycle `rampLevel` equals TOP_CODE. In the next cycle `rampLevel` is START_CODE and `seqPhase` is 3 (configuration wait).
- R5: `cfgStb` pulses exactly CFG_WAIT cycles after `sbyMonStb`. In that cycle `cfgPins` and `memSelCmp` are captured into `cfgHeld` and `memSelHeld`. Changes on those inputs at any other time have no effect on the held values.
- R6: If `slpAN` and `slpBN` are not both 1 at the capture cycle, a second climb starts from START_CODE in the next cycle. `railMonStb` then pulses 1+(TOP_CODE-START_CODE)*STEP_DIV cycles after `cfgStb`. Afterwards `seqPhase` is 5 (sleep park), `rampLevel` stays at START_CODE and `activeEn` stays 0.
- R7: If both sleep inputs are 1 at the capture cycle, `seqPhase` becomes 6 (main-supply wait). `activeEn` rises only after `mainGood` has been 1 for MAIN_WAIT consecutive cycles, observed MAIN_WAIT cycles after `mainGood` goes high. Any cycle with `mainGood` low restarts the count.
- R8: On the active path, `rampLevel` is START_CODE when `activeEn` rises. `railMonStb` pulses (TOP_CODE-START_CODE)*STEP_DIV cycles later. After that `seqPhase` is 8 (active park), `rampLevel` stays at ACT_PARK_CODE and `activeEn` stays 1.
- R9: A high `shutdown` at any clock edge puts the block in phase 0 with `rampLevel` 0 in the next cycle. Releasing it restarts the whole sequence from the fast charge.
- R10: `sbyMonStb`, `cfgStb` and `railMonStb` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (bias power-on reset) |
| shutdown | input | 1 | Forced shutdown; holds the sequence off while high |
| slpAN | input | 1 | First sleep-request input, active low |
| slpBN | input | 1 | Second sleep-request input, active low |
| mainGood | input | 1 | All main supplies above their thresholds |
| cfgPins | input | CFG_W | Rail configuration inputs, captured once per sequence |
| memSelCmp | input | 1 | Memory-voltage selection comparator output |
| rampLevel | output | RAMP_W | Digital soft-start ramp code |
| seqPhase | output | 4 | Sequence phase code |
| sbyMonStb | output | 1 | Pulse arming the standby-rail monitor |
| cfgStb | output | 1 | Configuration capture pulse |
| railMonStb | output | 1 | Pulse arming the remaining rail monitors |
| activeEn | output | 1 | External driver, dual-switch and clock-rail enable |
| cfgHeld | output | CFG_W | Captured configuration |
| memSelHeld | output | 1 | Captured memory-voltage selection |

## Verification
The bench uses a 6-bit ramp with FAST_CODE 8, START_CODE 10, TOP_CODE 22, ACT_PARK_CODE 19 and STEP_DIV 3, so each climb takes a few dozen cycles. It shortens CFG_WAIT to 7 and MAIN_WAIT to 12. With these values a single run covers both paths, a broken main-supply window and a shutdown in the middle of a ramp. The exact strobe spacing, and the cycle in which the drivers are enabled, can then be predicted and compared.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [3:0] {
    PH_OFF      = 4'd0,
    PH_FAST     = 4'd1,
    PH_SBY      = 4'd2,
    PH_CFG      = 4'd3,
    PH_RAIL     = 4'd4,
    PH_SLP_PARK = 4'd5,
    PH_MAIN     = 4'd6,
    PH_ACT      = 4'd7,
    PH_ACT_PARK = 4'd8
  } phase_e;

  typedef struct packed {
    logic clear;
    logic loadFast;
    logic loadStart;
    logic loadActPark;
    logic climb;
    logic tmrClear;
    logic tmrRun;
    logic cfgLatch;
  } seqCmd_t;

endpackage

// File: rtl/ss_datapath.sv
module ss_datapath
  import ss_pkg::*;
#(
  parameter int RAMP_W        = 8,
  parameter int FAST_CODE     = 85,
  parameter int START_CODE    = 106,
  parameter int TOP_CODE      = 234,
  parameter int ACT_PARK_CODE = 208,
  parameter int STEP_DIV      = 16,
  parameter int CFG_WAIT      = 300000,
  parameter int MAIN_WAIT     = 2500000,
  parameter int CFG_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [CFG_W-1:0]  cfgPins,
  input  logic              memSelCmp,
  output logic [RAMP_W-1:0] rampLevel,
  output logic              atTop,
  output logic              cfgDone,
  output logic              mainDone,
  output logic [CFG_W-1:0]  cfgHeld,
  output logic              memSelHeld
);

  localparam int TMR_MAX = (CFG_WAIT > MAIN_WAIT) ? CFG_WAIT : MAIN_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int DIV_W   = $clog2(STEP_DIV + 1);

  localparam logic [RAMP_W-1:0] FAST_V  = RAMP_W'(FAST_CODE);
  localparam logic [RAMP_W-1:0] START_V = RAMP_W'(START_CODE);
  localparam logic [RAMP_W-1:0] TOP_V   = RAMP_W'(TOP_CODE);
  localparam logic [RAMP_W-1:0] PARK_V  = RAMP_W'(ACT_PARK_CODE);
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(STEP_DIV - 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(TMR_MAX - 1);
  localparam logic [TMR_W-1:0]  CFG_LAST = TMR_W'(CFG_WAIT - 1);
  localparam logic [TMR_W-1:0]  MAIN_LAST = TMR_W'(MAIN_WAIT - 1);

  logic [RAMP_W-1:0] rampQ;
  logic [DIV_W-1:0]  divCnt;
  logic [TMR_W-1:0]  tmrCnt;
  logic              stepNow;

  assign stepNow = cmd.climb && (divCnt == DIV_LAST);

  // ramp code register with its step prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampQ  <= '0;
      divCnt <= '0;
    end else begin
      if (cmd.clear)            rampQ <= '0;
      else if (cmd.loadFast)    rampQ <= FAST_V;
      else if (cmd.loadStart)   rampQ <= START_V;
      else if (cmd.loadActPark) rampQ <= PARK_V;
      else if (stepNow && rampQ != TOP_V) rampQ <= rampQ + RAMP_W'(1);

      if (cmd.clear || !cmd.climb || stepNow) divCnt <= '0;
      else                                    divCnt <= divCnt + DIV_W'(1);
    end
  end

  // one timer serves both waits; it saturates instead of wrapping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  tmrCnt <= '0;
    else if (cmd.clear || cmd.tmrClear)         tmrCnt <= '0;
    else if (cmd.tmrRun && tmrCnt != TMR_LAST)  tmrCnt <= tmrCnt + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgHeld    <= '0;
      memSelHeld <= 1'b0;
    end else if (cmd.cfgLatch) begin
      cfgHeld    <= cfgPins;
      memSelHeld <= memSelCmp;
    end
  end

  assign rampLevel = rampQ;
  assign atTop     = (rampQ == TOP_V);
  assign cfgDone   = (tmrCnt == CFG_LAST);
  assign mainDone  = (tmrCnt == MAIN_LAST);

endmodule

// File: rtl/ss_control.sv
module ss_control
  import ss_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    shutdown,
  input  logic    slpAN,
  input  logic    slpBN,
  input  logic    mainGood,
  input  logic    atTop,
  input  logic    cfgDone,
  input  logic    mainDone,
  output seqCmd_t cmd,
  output phase_e  phase,
  output logic    sbyMonStb,
  output logic    cfgStb,
  output logic    railMonStb,
  output logic    activeEn
);

  phase_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= PH_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    cmd        = '0;
    sbyMonStb  = 1'b0;
    cfgStb     = 1'b0;
    railMonStb = 1'b0;
    if (shutdown) begin
      cmd.clear = 1'b1;
      stateD    = PH_OFF;
    end else begin
      unique case (stateQ)
        PH_OFF: begin
          cmd.clear = 1'b1;
          stateD    = PH_FAST;
        end
        PH_FAST: begin
          cmd.loadFast = 1'b1;
          stateD       = PH_SBY;
        end
        PH_SBY: begin
          if (atTop) begin
            sbyMonStb     = 1'b1;
            cmd.loadStart = 1'b1;
            cmd.tmrClear  = 1'b1;
            stateD        = PH_CFG;
          end else begin
            cmd.climb = 1'b1;
          end
        end
        PH_CFG: begin
          cmd.tmrRun = 1'b1;
          if (cfgDone) begin
            cfgStb       = 1'b1;
            cmd.cfgLatch = 1'b1;
            cmd.tmrClear = 1'b1;
            stateD       = (slpAN && slpBN) ? PH_MAIN : PH_RAIL;
          end
        end
        PH_RAIL: begin
          if (atTop) begin
            railMonStb    = 1'b1;
            cmd.loadStart = 1'b1;
            stateD        = PH_SLP_PARK;
          end else begin
            cmd.climb = 1'b1;
          end
        end
        PH_MAIN: begin
          if (!mainGood)     cmd.tmrClear = 1'b1;
          else if (mainDone) stateD = PH_ACT;
          else               cmd.tmrRun = 1'b1;
        end
        PH_ACT: begin
          if (atTop) begin
            railMonStb      = 1'b1;
            cmd.loadActPark = 1'b1;
            stateD          = PH_ACT_PARK;
          end else begin
            cmd.climb = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign phase    = stateQ;
  assign activeEn = (stateQ == PH_ACT) || (stateQ == PH_ACT_PARK);

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int RAMP_W        = 8,
  parameter int FAST_CODE     = 85,
  parameter int START_CODE    = 106,
  parameter int TOP_CODE      = 234,
  parameter int ACT_PARK_CODE = 208,
  parameter int STEP_DIV      = 16,
  parameter int CFG_WAIT      = 300000,
  parameter int MAIN_WAIT     = 2500000,
  parameter int CFG_W         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shutdown,
  input  logic              slpAN,
  input  logic              slpBN,
  input  logic              mainGood,
  input  logic [CFG_W-1:0]  cfgPins,
  input  logic              memSelCmp,
  output logic [RAMP_W-1:0] rampLevel,
  output logic [3:0]        seqPhase,
  output logic              sbyMonStb,
  output logic              cfgStb,
  output logic              railMonStb,
  output logic              activeEn,
  output logic [CFG_W-1:0]  cfgHeld,
  output logic              memSelHeld
);

  seqCmd_t cmd;
  phase_e  phase;
  logic    atTop, cfgDone, mainDone;

  ss_control u_ctrl (
    .clk(clk), .rstN(rstN), .shutdown(shutdown), .slpAN(slpAN), .slpBN(slpBN),
    .mainGood(mainGood), .atTop(atTop), .cfgDone(cfgDone), .mainDone(mainDone),
    .cmd(cmd), .phase(phase), .sbyMonStb(sbyMonStb), .cfgStb(cfgStb),
    .railMonStb(railMonStb), .activeEn(activeEn)
  );

  ss_datapath #(
    .RAMP_W(RAMP_W), .FAST_CODE(FAST_CODE), .START_CODE(START_CODE),
    .TOP_CODE(TOP_CODE), .ACT_PARK_CODE(ACT_PARK_CODE), .STEP_DIV(STEP_DIV),
    .CFG_WAIT(CFG_WAIT), .MAIN_WAIT(MAIN_WAIT), .CFG_W(CFG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cfgPins(cfgPins), .memSelCmp(memSelCmp),
    .rampLevel(rampLevel), .atTop(atTop), .cfgDone(cfgDone), .mainDone(mainDone),
    .cfgHeld(cfgHeld), .memSelHeld(memSelHeld)
  );

  assign seqPhase = phase;

endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk #(
  parameter int RAMP_W        = 8,
  parameter int FAST_CODE     = 85,
  parameter int START_CODE    = 106,
  parameter int ACT_PARK_CODE = 208,
  parameter int CFG_W         = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              shutdown,
  input logic              mainGood,
  input logic [RAMP_W-1:0] rampLevel,
  input logic [3:0]        seqPhase,
  input logic              sbyMonStb,
  input logic              cfgStb,
  input logic              railMonStb,
  input logic              activeEn,
  input logic [CFG_W-1:0]  cfgHeld,
  input logic              memSelHeld
);

  localparam logic [RAMP_W-1:0] FAST_V  = RAMP_W'(FAST_CODE);
  localparam logic [RAMP_W-1:0] START_V = RAMP_W'(START_CODE);
  localparam logic [RAMP_W-1:0] PARK_V  = RAMP_W'(ACT_PARK_CODE);

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase == 4'd0) |-> (rampLevel == '0 && !activeEn));

  a_r2_fast_load: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase == 4'd1 && !shutdown) |=> (rampLevel == FAST_V));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    ((seqPhase == 4'd2 || seqPhase == 4'd4 || seqPhase == 4'd7) && !shutdown
      && !sbyMonStb && !railMonStb)
    |=> (rampLevel == $past(rampLevel) || rampLevel == $past(rampLevel) + RAMP_W'(1)));

  a_r4_sby_reload: assert property (@(posedge clk) disable iff (!rstN)
    sbyMonStb |=> (rampLevel == START_V && seqPhase == 4'd3));

  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStb |=> ($stable(cfgHeld) && $stable(memSelHeld)));

  a_r6_sleep_park: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase == 4'd5) |-> (rampLevel == START_V && !activeEn));

  a_r7_wait_gate: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase == 4'd6 && !mainGood) |=> !activeEn);

  a_r8_act_park: assert property (@(posedge clk) disable iff (!rstN)
    (seqPhase == 4'd8) |-> (rampLevel == PARK_V && activeEn));

  a_r9_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> (seqPhase == 4'd0));

  a_r10_strobes: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sbyMonStb, cfgStb, railMonStb}));

endmodule

bind softstart_seq softstart_seq_chk #(
  .RAMP_W(RAMP_W), .FAST_CODE(FAST_CODE), .START_CODE(START_CODE),
  .ACT_PARK_CODE(ACT_PARK_CODE), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .shutdown(shutdown), .mainGood(mainGood),
  .rampLevel(rampLevel), .seqPhase(seqPhase), .sbyMonStb(sbyMonStb),
  .cfgStb(cfgStb), .railMonStb(railMonStb), .activeEn(activeEn),
  .cfgHeld(cfgHeld), .memSelHeld(memSelHeld)
);

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;

  localparam int RW = 6, FASTC = 8, STARTC = 10, TOPC = 22, PARKC = 19;
  localparam int SD = 3, CW = 7, MW = 12;

  logic clk = 1'b0;
  logic rstN, shutdown, slpAN, slpBN, mainGood, memSelCmp;
  logic [1:0] cfgPins;
  logic [RW-1:0] rampLevel;
  logic [3:0] seqPhase;
  logic sbyMonStb, cfgStb, railMonStb, activeEn, memSelHeld;
  logic [1:0] cfgHeld;

  always #2.5 clk = ~clk;

  softstart_seq #(
    .RAMP_W(RW), .FAST_CODE(FASTC), .START_CODE(STARTC), .TOP_CODE(TOPC),
    .ACT_PARK_CODE(PARKC), .STEP_DIV(SD), .CFG_WAIT(CW), .MAIN_WAIT(MW), .CFG_W(2)
  ) u_dut (
    .clk(clk), .rstN(rstN), .shutdown(shutdown), .slpAN(slpAN), .slpBN(slpBN),
    .mainGood(mainGood), .cfgPins(cfgPins), .memSelCmp(memSelCmp),
    .rampLevel(rampLevel), .seqPhase(seqPhase), .sbyMonStb(sbyMonStb),
    .cfgStb(cfgStb), .railMonStb(railMonStb), .activeEn(activeEn),
    .cfgHeld(cfgHeld), .memSelHeld(memSelHeld)
  );

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    kind;
    int    gap;
    int    ramp;
    string tag;
  } exp_t;
  exp_t expQ[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushExp(int kind, int gap, int ramp, string tag);
    exp_t e;
    e.kind = kind; e.gap = gap; e.ramp = ramp; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: event kinds 1 standby strobe, 2 capture strobe, 3 rail strobe, 4 enable rise
  int cyc = 0, lastEvt = 0, dwell = 0;
  logic prevAct = 1'b0;
  int prevRamp = 0;

  task automatic takeEvt(int kind);
    exp_t e;
    if (expQ.size() == 0) begin
      check(1'b0, "R10 unexpected event", kind, 0);
    end else begin
      e = expQ.pop_front();
      check(e.kind == kind, e.tag, kind, e.kind);
      if (e.gap >= 0) check((cyc - lastEvt) == e.gap, e.tag, cyc - lastEvt, e.gap);
      check(int'(rampLevel) == e.ramp, e.tag, int'(rampLevel), e.ramp);
    end
    lastEvt = cyc;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (sbyMonStb || cfgStb || railMonStb)
        check($countones({sbyMonStb, cfgStb, railMonStb}) == 1, "R10 strobes",
              $countones({sbyMonStb, cfgStb, railMonStb}), 1);
      if (sbyMonStb)  takeEvt(1);
      if (cfgStb)     takeEvt(2);
      if (railMonStb) takeEvt(3);
      if (activeEn && !prevAct) takeEvt(4);
      dwell++;
      if (int'(rampLevel) != prevRamp) begin
        if (prevRamp == 0)
          check(int'(rampLevel) == FASTC, "R2 fast charge", int'(rampLevel), FASTC);
        else if (int'(rampLevel) > prevRamp) begin
          check(int'(rampLevel) == prevRamp + 1, "R3 unit step", int'(rampLevel), prevRamp + 1);
          if (prevRamp != FASTC && prevRamp != STARTC)
            check(dwell == SD, "R3 step rate", dwell, SD);
        end
        dwell = 0;
      end
      prevAct  = activeEn;
      prevRamp = int'(rampLevel);
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=sequence done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; shutdown = 1'b0; slpAN = 1'b1; slpBN = 1'b0;
    mainGood = 1'b0; cfgPins = 2'b01; memSelCmp = 1'b1;
    repeat (3) @(negedge clk);
    check(seqPhase == 0, "R1 reset phase", seqPhase, 0);
    check(rampLevel == 0, "R1 reset ramp", rampLevel, 0);
    check(!activeEn && !sbyMonStb && !cfgStb && !railMonStb, "R1 reset outputs",
          {activeEn, sbyMonStb, cfgStb, railMonStb}, 0);

    // sleep path
    pushExp(1, -1, TOPC, "R4 standby strobe");
    pushExp(2, CW, STARTC, "R5 capture gap");
    pushExp(3, 1 + (TOPC - STARTC) * SD, TOPC, "R6 sleep rail strobe");
    rstN = 1'b1;
    while (!cfgStb) @(negedge clk);
    @(negedge clk);
    check(cfgHeld == 2'b01, "R5 captured cfg", cfgHeld, 1);
    check(memSelHeld == 1'b1, "R5 captured memsel", memSelHeld, 1);
    cfgPins = 2'b10; memSelCmp = 1'b0;
    while (seqPhase != 5) @(negedge clk);
    repeat (10) @(negedge clk);
    check(seqPhase == 5, "R6 sleep park phase", seqPhase, 5);
    check(rampLevel == STARTC, "R6 park ramp", rampLevel, STARTC);
    check(!activeEn, "R6 drivers off", activeEn, 0);
    check(cfgHeld == 2'b01, "R5 cfg ignored later", cfgHeld, 1);
    check(memSelHeld == 1'b1, "R5 memsel ignored later", memSelHeld, 1);

    // shutdown, then active path
    shutdown = 1'b1;
    @(negedge clk);
    check(seqPhase == 0, "R9 shutdown phase", seqPhase, 0);
    check(rampLevel == 0, "R9 shutdown ramp", rampLevel, 0);
    check(expQ.size() == 0, "R6 events consumed", expQ.size(), 0);
    slpAN = 1'b1; slpBN = 1'b1;
    pushExp(1, -1, TOPC, "R4 standby strobe again");
    pushExp(2, CW, STARTC, "R5 capture gap again");
    pushExp(4, -1, STARTC, "R8 ramp at enable");
    pushExp(3, (TOPC - STARTC) * SD, TOPC, "R8 active rail strobe");
    @(negedge clk);
    shutdown = 1'b0;
    while (seqPhase != 6) @(negedge clk);
    check(cfgHeld == 2'b10, "R5 recapture cfg", cfgHeld, 2);
    check(memSelHeld == 1'b0, "R5 recapture memsel", memSelHeld, 0);
    repeat (20) @(negedge clk);
    check(!activeEn, "R7 no enable without main good", activeEn, 0);
    mainGood = 1'b1;
    repeat (5) @(negedge clk);
    mainGood = 1'b0;
    repeat (3) @(negedge clk);
    check(!activeEn, "R7 broken window", activeEn, 0);
    mainGood = 1'b1;
    repeat (MW - 1) @(negedge clk);
    check(!activeEn, "R7 one cycle early", activeEn, 0);
    @(negedge clk);
    check(activeEn, "R7 enable on time", activeEn, 1);
    while (seqPhase != 8) @(negedge clk);
    repeat (5) @(negedge clk);
    check(rampLevel == PARKC, "R8 active park ramp", rampLevel, PARKC);
    check(activeEn, "R8 enable held", activeEn, 1);

    // shutdown in the middle of the standby climb
    shutdown = 1'b1;
    @(negedge clk);
    check(!activeEn, "R9 shutdown drops enable", activeEn, 1'b0);
    check(expQ.size() == 0, "R8 events consumed", expQ.size(), 0);
    slpAN = 1'b0; slpBN = 1'b0; mainGood = 1'b0;
    pushExp(1, -1, TOPC, "R9 restart standby strobe");
    pushExp(2, CW, STARTC, "R9 restart capture");
    pushExp(3, 1 + (TOPC - STARTC) * SD, TOPC, "R9 restart rail strobe");
    shutdown = 1'b0;
    while (rampLevel < 12) @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    check(seqPhase == 0, "R9 mid-ramp shutdown phase", seqPhase, 0);
    check(rampLevel == 0, "R9 mid-ramp shutdown ramp", rampLevel, 0);
    shutdown = 1'b0;
    while (seqPhase != 5) @(negedge clk);
    @(negedge clk);
    check(rampLevel == STARTC, "R9 restart completes", rampLevel, STARTC);
    check(expQ.size() == 0, "R10 all events seen", expQ.size(), 0);

    summary();
    $finish;
  end

endmodule